// File: doc/BRIEF.md
# Comparator Edge Event Controller

This block is the clocked back end of an analog comparator. The raw comparator bit arrives asynchronously. It passes through a synchronizer chain and can optionally be inverted. An edge detector then watches the processed level and latches an event flag when it sees the selected transition (rising, falling or either). The flag can raise an interrupt through a set/clear mask pair. A fault output follows either the latched flag or the live processed level, and can also be forced low.

Software reaches the block over a simple 32-bit register bus. A write strobe or a read strobe is qualified by a byte address. Read data is registered and appears one clock after the read strobe. The block also stores the comparator input-select codes and the analog current and hysteresis settings, and presents them on output ports; the analog parts themselves sit outside. A 24-bit key guards a protection bit. While that bit is set, the mode and analog settings are frozen, and each blocked attempt is recorded in a sticky violation bit.

Top module: `cmp_edge_ctrl`

## Requirements
- R1: The raw comparator bit passes through SYNC_STAGES flip-flops. Bit 1 of the status word (byte address 0x30) reports the processed level, which is the synchronized bit XOR the invert setting.
- R2: The mode word (address 0x04) keeps only the bits in mask 0x7777: minus select [2:0], plus select [6:4], enable [8], edge code [10:9], invert [12], fault source [13] and fault enable [14]. It reads back masked, and the two select fields drive `sel_minus` and `sel_plus`.
- R3: Edge code 0 flags rising transitions of the processed level, code 1 flags falling ones and code 2 flags both. Code 3 flags none.
- R4: With invert set, the comparator bit is complemented before edge detection, before the status level and before the fault path.
- R5: No new event flag is set while the enable bit is 0.
- R6: Bit 0 of the status word is the event flag. A status read returns the flag and clears it. An edge detected in the same cycle as a status read leaves the flag set.
- R7: Bit 31 of the status word reads 1 while the enable bit is 0, and 0 otherwise.
- R8: `fault` is 0 one cycle after fault enable is 0. With fault enable at 1, it follows the event flag when fault source is 0 and the processed level when fault source is 1, one cycle later.
- R9: A write with bit 0 set to address 0x24 sets the interrupt mask, and the same write to 0x28 clears it. Address 0x2C reads the mask in bit 0. `irq` is the event flag AND the mask, one cycle later.
- R10: A write with bit 0 set to address 0x00 returns the mode, analog, mask, flag, protection and violation state to zero. It also clears `irq` and `fault` on the next edge.
- R11: Address 0xE4 holds the protection bit in bit 0. A write changes that bit only when bits 31:8 equal 0x414343. The key field always reads 0.
- R12: While protection is on, writes to addresses 0x04 and 0x94 are ignored and set a violation bit. The violation bit reads in bit 0 of 0xE8 and clears on that read, unless a new violation occurs in the same cycle.
- R13: Address 0x94 holds the current select in bit 0 (0 = low power, 1 = high speed) and the hysteresis code in bits 2:1. These drive `cur_sel` and `hyst_sel`.
- R14: After `rst`, all outputs are 0 and the status word reads 0x8000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| cmp_raw | input | 1 | Asynchronous comparator output |
| irq | output | 1 | Edge event interrupt |
| fault | output | 1 | Fault output |
| sel_minus | output | 3 | Minus input select code |
| sel_plus | output | 3 | Plus input select code |
| cmp_enable | output | 1 | Comparator enable |
| cur_sel | output | 1 | Current select (low power / high speed) |
| hyst_sel | output | 2 | Hysteresis code |

## Verification
The bench builds the block with its defaults: SYNC_STAGES = 2, ADDR_W = 8 and the key 0x414343. With a two-stage chain, the cycle in which an edge is detected can be counted exactly from the input change. This lets a status read be placed on that same cycle to exercise the set-over-clear priority. An 8-bit address reaches every register up to 0xE8. The reference model tracks the synchronizer as a queue whose depth equals the stage count. It compares every output on every clock, including level-versus-flag fault selection, invert changes that themselves create edges, and protection violations.

// File: rtl/cmpe_pkg.sv
package cmpe_pkg;
  localparam int DATA_W   = 32;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_MODE = 'h04;
  localparam int OFF_IEN  = 'h24;
  localparam int OFF_IDIS = 'h28;
  localparam int OFF_IMSK = 'h2C;
  localparam int OFF_STAT = 'h30;
  localparam int OFF_ANA  = 'h94;
  localparam int OFF_WPM  = 'hE4;
  localparam int OFF_WPS  = 'hE8;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } edge_mode_e;

  typedef struct packed {
    logic       fault_en;
    logic       fault_src;
    logic       invert;
    edge_mode_e edge_mode;
    logic       enable;
    logic [2:0] sel_p;
    logic [2:0] sel_m;
  } mode_t;

  function automatic logic [DATA_W-1:0] pack_mode(input mode_t m);
    return {17'b0, m.fault_en, m.fault_src, m.invert, 1'b0, m.edge_mode,
            m.enable, 1'b0, m.sel_p, 1'b0, m.sel_m};
  endfunction
endpackage

// File: rtl/cmpe_sync.sv
module cmpe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= din;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cmpe_edge.sv
module cmpe_edge
  import cmpe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_clr,
  input  logic       sync_lvl,
  input  logic       invert,
  input  logic       enable,
  input  edge_mode_e edge_mode,
  input  logic       stat_rd,
  output logic       level,
  output logic       flag
);
  logic prev_q;
  logic hit;

  assign level = sync_lvl ^ invert;

  always_comb begin
    hit = 1'b0;
    if (enable) begin
      case (edge_mode)
        EDGE_RISE: hit = level & ~prev_q;
        EDGE_FALL: hit = ~level & prev_q;
        EDGE_BOTH: hit = level ^ prev_q;
        default:   hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) flag <= 1'b0;
    else if (hit)        flag <= 1'b1;
    else if (stat_rd)    flag <= 1'b0;
  end

  // R6: a detected edge always lands in the flag, even against a read
  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && !soft_clr) |=> flag);
  // R6: a read with no competing edge empties the flag
  p_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !hit) |=> !flag);
  // R5: no flag rises while detection is off
  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !$rose(flag));
endmodule

// File: rtl/cmpe_regs.sv
module cmpe_regs
  import cmpe_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          KEY_W  = 24,
  parameter logic [23:0] KEY    = 24'h414343
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              flag,
  input  logic              level,
  output mode_t             mode_q,
  output logic              cur_q,
  output logic [1:0]        hyst_q,
  output logic              imask_q,
  output logic              soft_clr,
  output logic              stat_rd,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_IDIS = ADDR_W'(OFF_IDIS);
  localparam logic [ADDR_W-1:0] A_IMSK = ADDR_W'(OFF_IMSK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_ANA  = ADDR_W'(OFF_ANA);
  localparam logic [ADDR_W-1:0] A_WPM  = ADDR_W'(OFF_WPM);
  localparam logic [ADDR_W-1:0] A_WPS  = ADDR_W'(OFF_WPS);
  localparam int KEY_LO = DATA_W - KEY_W;

  logic wp_en_q, viol_q;
  logic wr_mode, wr_ana, guarded_wr, key_ok, wps_rd;
  logic [DATA_W-1:0] rd_mux;

  assign soft_clr   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
  assign wr_mode    = bus_wr && (bus_addr == A_MODE);
  assign wr_ana     = bus_wr && (bus_addr == A_ANA);
  assign guarded_wr = (wr_mode || wr_ana) && wp_en_q;
  assign key_ok     = (bus_wdata[DATA_W-1:KEY_LO] == KEY);
  assign stat_rd    = bus_rd && (bus_addr == A_STAT);
  assign wps_rd     = bus_rd && (bus_addr == A_WPS);

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      mode_q  <= '0;
      cur_q   <= 1'b0;
      hyst_q  <= 2'b00;
      imask_q <= 1'b0;
      wp_en_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      if (wr_mode && !wp_en_q)
        mode_q <= '{fault_en:  bus_wdata[14],
                    fault_src: bus_wdata[13],
                    invert:    bus_wdata[12],
                    edge_mode: edge_mode_e'(bus_wdata[10:9]),
                    enable:    bus_wdata[8],
                    sel_p:     bus_wdata[6:4],
                    sel_m:     bus_wdata[2:0]};
      if (wr_ana && !wp_en_q) begin
        cur_q  <= bus_wdata[0];
        hyst_q <= bus_wdata[2:1];
      end
      if (bus_wr && (bus_addr == A_IEN) && bus_wdata[0])  imask_q <= 1'b1;
      if (bus_wr && (bus_addr == A_IDIS) && bus_wdata[0]) imask_q <= 1'b0;
      if (bus_wr && (bus_addr == A_WPM) && key_ok)        wp_en_q <= bus_wdata[0];
      if (guarded_wr)  viol_q <= 1'b1;
      else if (wps_rd) viol_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  rd_mux = pack_mode(mode_q);
      A_IMSK:  rd_mux = {31'b0, imask_q};
      A_STAT:  rd_mux = {~mode_q.enable, 29'b0, level, flag};
      A_ANA:   rd_mux = {29'b0, hyst_q, cur_q};
      A_WPM:   rd_mux = {31'b0, wp_en_q};
      A_WPS:   rd_mux = {31'b0, viol_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (bus_rd) rdata <= rd_mux;
    else             rdata <= '0;
  end

  // R12: a guarded mode write leaves the mode untouched
  p_wp_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && wp_en_q) |=> $stable(mode_q));
  // R12: every blocked attempt is recorded
  p_viol_set_r12: assert property (@(posedge clk) disable iff (rst)
    guarded_wr |=> viol_q);
  // R11: a wrong key never moves the protection bit
  p_key_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == A_WPM) && !key_ok) |=> $stable(wp_en_q));
endmodule

// File: rtl/cmp_edge_ctrl.sv
module cmp_edge_ctrl
  import cmpe_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [23:0] WP_KEY      = 24'h414343
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cmp_raw,
  output logic              irq,
  output logic              fault,
  output logic [2:0]        sel_minus,
  output logic [2:0]        sel_plus,
  output logic              cmp_enable,
  output logic              cur_sel,
  output logic [1:0]        hyst_sel
);
  mode_t mode;
  logic  sync_lvl, level, flag, imask, soft_clr, stat_rd, cur_q;
  logic [1:0] hyst_q;

  cmpe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cmp_raw), .dout(sync_lvl)
  );

  cmpe_regs #(.ADDR_W(ADDR_W), .KEY_W(24), .KEY(WP_KEY)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag(flag), .level(level),
    .mode_q(mode), .cur_q(cur_q), .hyst_q(hyst_q), .imask_q(imask),
    .soft_clr(soft_clr), .stat_rd(stat_rd), .rdata(bus_rdata)
  );

  cmpe_edge u_edge (
    .clk(clk), .rst(rst), .soft_clr(soft_clr), .sync_lvl(sync_lvl),
    .invert(mode.invert), .enable(mode.enable), .edge_mode(mode.edge_mode),
    .stat_rd(stat_rd), .level(level), .flag(flag)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      irq   <= 1'b0;
      fault <= 1'b0;
    end else begin
      irq   <= flag & imask;
      fault <= mode.fault_en & (mode.fault_src ? level : flag);
    end
  end

  assign sel_minus  = mode.sel_m;
  assign sel_plus   = mode.sel_p;
  assign cmp_enable = mode.enable;
  assign cur_sel    = cur_q;
  assign hyst_sel   = hyst_q;

  // R8: with fault enable off the output is low on the following cycle
  p_fault_off_r8: assert property (@(posedge clk) disable iff (rst)
    !mode.fault_en |=> !fault);
  // R9: interrupt never asserts without the mask having been set
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    !imask |=> !irq);
endmodule

// File: tb/sim_cmp_edge_ctrl.sv
`timescale 1ns/1ps
module sim_cmp_edge_ctrl;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, cmp_raw = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, fault, cmp_enable, cur_sel;
  logic [2:0] sel_minus, sel_plus;
  logic [1:0] hyst_sel;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_edge_ctrl #(.ADDR_W(8), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_raw(cmp_raw), .irq(irq), .fault(fault), .sel_minus(sel_minus),
    .sel_plus(sel_plus), .cmp_enable(cmp_enable), .cur_sel(cur_sel),
    .hyst_sel(hyst_sel)
  );

  // ---------------- behavioural reference model ----------------
  int sq[$];
  int m_sm, m_sp, m_en, m_et, m_inv, m_fs, m_fe, m_cur, m_hy;
  int m_mask, m_flag, m_prev, m_wp, m_viol, m_irq, m_fault;
  logic [31:0] m_rdata;

  task automatic model_zero();
    m_sm = 0; m_sp = 0; m_en = 0; m_et = 0; m_inv = 0; m_fs = 0; m_fe = 0;
    m_cur = 0; m_hy = 0; m_mask = 0; m_flag = 0; m_wp = 0; m_viol = 0;
  endtask

  initial begin
    model_zero();
    m_prev = 0; m_irq = 0; m_fault = 0; m_rdata = '0;
    for (int i = 0; i < SYNC; i++) sq.push_back(0);
  end

  always @(posedge clk) begin
    int lvl, hit, srst;
    if (rst) begin
      model_zero();
      m_prev = 0; m_irq = 0; m_fault = 0; m_rdata = '0;
      sq.delete();
      for (int i = 0; i < SYNC; i++) sq.push_back(0);
    end else begin
      lvl = sq[0] ^ m_inv;
      hit = 0;
      if (m_en == 1) begin
        if (m_et == 0 && lvl == 1 && m_prev == 0) hit = 1;
        if (m_et == 1 && lvl == 0 && m_prev == 1) hit = 1;
        if (m_et == 2 && lvl != m_prev) hit = 1;
      end
      srst = (bus_wr && bus_addr == 8'h00 && bus_wdata[0]) ? 1 : 0;
      m_rdata = '0;
      if (bus_rd) begin
        case (bus_addr)
          8'h04: m_rdata = 32'((m_fe << 14) | (m_fs << 13) | (m_inv << 12) |
                               (m_et << 9) | (m_en << 8) | (m_sp << 4) | m_sm);
          8'h2C: m_rdata = 32'(m_mask);
          8'h30: m_rdata = {(m_en == 0), 29'b0, lvl[0], m_flag[0]};
          8'h94: m_rdata = 32'((m_hy << 1) | m_cur);
          8'hE4: m_rdata = 32'(m_wp);
          8'hE8: m_rdata = 32'(m_viol);
          default: m_rdata = '0;
        endcase
      end
      if (srst == 1) begin
        m_irq = 0; m_fault = 0;
      end else begin
        m_irq = m_flag & m_mask;
        m_fault = (m_fe == 1) ? ((m_fs == 1) ? lvl : m_flag) : 0;
      end
      if (srst == 1) begin
        model_zero();
      end else begin
        if (hit == 1) m_flag = 1;
        else if (bus_rd && bus_addr == 8'h30) m_flag = 0;
        if (bus_wr && (bus_addr == 8'h04 || bus_addr == 8'h94) && m_wp == 1)
          m_viol = 1;
        else if (bus_rd && bus_addr == 8'hE8)
          m_viol = 0;
        if (bus_wr && m_wp == 0 && bus_addr == 8'h04) begin
          m_sm = int'(bus_wdata[2:0]); m_sp = int'(bus_wdata[6:4]);
          m_en = int'(bus_wdata[8]);   m_et = int'(bus_wdata[10:9]);
          m_inv = int'(bus_wdata[12]); m_fs = int'(bus_wdata[13]);
          m_fe = int'(bus_wdata[14]);
        end
        if (bus_wr && m_wp == 0 && bus_addr == 8'h94) begin
          m_cur = int'(bus_wdata[0]); m_hy = int'(bus_wdata[2:1]);
        end
        if (bus_wr && bus_addr == 8'h24 && bus_wdata[0]) m_mask = 1;
        if (bus_wr && bus_addr == 8'h28 && bus_wdata[0]) m_mask = 0;
        if (bus_wr && bus_addr == 8'hE4 && bus_wdata[31:8] == 24'h414343)
          m_wp = int'(bus_wdata[0]);
      end
      m_prev = lvl;
      void'(sq.pop_front());
      sq.push_back(int'(cmp_raw));
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (irq !== m_irq[0] || fault !== m_fault[0] || bus_rdata !== m_rdata ||
          sel_minus !== 3'(m_sm) || sel_plus !== 3'(m_sp) ||
          cmp_enable !== m_en[0] || cur_sel !== m_cur[0] || hyst_sel !== 2'(m_hy)) begin
        n_fail++;
        $display("FAIL R2/R6/R8/R9/R13 cycle compare at %0t: got irq=%0b fault=%0b rdata=%h cfg=%0d/%0d/%0b/%0b/%0d exp irq=%0d fault=%0d rdata=%h cfg=%0d/%0d/%0d/%0d/%0d",
                 $time, irq, fault, bus_rdata, sel_minus, sel_plus, cmp_enable, cur_sel, hyst_sel,
                 m_irq, m_fault, m_rdata, m_sm, m_sp, m_en, m_cur, m_hy);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_raw(input logic v);
    cmp_raw = v;
    idle(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(4);
    rst = 1'b0;
    idle(1);
    // R14 reset state
    chk("R14 irq", {31'b0, irq}, 32'h0);
    chk("R14 fault", {31'b0, fault}, 32'h0);
    bus_read(8'h04, d); chk("R14 mode", d, 32'h0);
    bus_read(8'h30, d); chk("R14/R7 status", d, 32'h8000_0000);
    // R2 mask and select outputs
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, d); chk("R2 mode mask", d, 32'h0000_7777);
    chk("R2 sel_minus", {29'b0, sel_minus}, 32'h7);
    chk("R2 sel_plus", {29'b0, sel_plus}, 32'h7);
    bus_write(8'h04, 32'h0);
    // R13 analog settings
    bus_write(8'h94, 32'hFFFF_FFFF);
    bus_read(8'h94, d); chk("R13 ana mask", d, 32'h7);
    chk("R13 outs", {29'b0, hyst_sel, cur_sel}, 32'h7);
    bus_write(8'h94, 32'h2);
    bus_read(8'h94, d); chk("R13 ana value", d, 32'h2);
    chk("R13 hyst", {30'b0, hyst_sel}, 32'h1);
    // R1 / R3 rising
    bus_write(8'h04, 32'h100);
    drive_raw(1'b1);
    bus_read(8'h30, d); chk("R1/R3 rising seen", d, 32'h3);
    bus_read(8'h30, d); chk("R6 clear on read", d, 32'h2);
    drive_raw(1'b0);
    bus_read(8'h30, d); chk("R3 rising ignores fall", d, 32'h0);
    // R3 falling
    bus_write(8'h04, 32'h300);
    drive_raw(1'b1);
    bus_read(8'h30, d); chk("R3 falling ignores rise", d, 32'h2);
    drive_raw(1'b0);
    bus_read(8'h30, d); chk("R3 falling seen", d, 32'h1);
    // R3 both
    bus_write(8'h04, 32'h500);
    drive_raw(1'b1);
    bus_read(8'h30, d); chk("R3 both rise", d, 32'h3);
    drive_raw(1'b0);
    bus_read(8'h30, d); chk("R3 both fall", d, 32'h1);
    // R3 code 3
    bus_write(8'h04, 32'h700);
    drive_raw(1'b1);
    bus_read(8'h30, d); chk("R3 code3 rise", d, 32'h2);
    drive_raw(1'b0);
    bus_read(8'h30, d); chk("R3 code3 fall", d, 32'h0);
    // R4 invert: switching invert with raw low makes a rising processed edge
    bus_write(8'h04, 32'h1100);
    idle(2);
    bus_read(8'h30, d); chk("R4 inverted level", d, 32'h3);
    drive_raw(1'b1);
    bus_read(8'h30, d); chk("R4 inverted fall ignored", d, 32'h0);
    drive_raw(1'b0);
    bus_read(8'h30, d); chk("R4 inverted rise", d, 32'h3);
    // R5 / R7 disabled
    bus_write(8'h04, 32'h400);
    drive_raw(1'b1);
    drive_raw(1'b0);
    bus_read(8'h30, d); chk("R5/R7 disabled", d, 32'h8000_0000);
    // R9 interrupt mask
    bus_write(8'h24, 32'h1);
    bus_read(8'h2C, d); chk("R9 mask set", d, 32'h1);
    bus_write(8'h04, 32'h500);
    drive_raw(1'b1);
    idle(1);
    chk("R9 irq on", {31'b0, irq}, 32'h1);
    bus_read(8'h30, d);
    idle(2);
    chk("R9 irq off after read", {31'b0, irq}, 32'h0);
    drive_raw(1'b0);
    idle(1);
    chk("R9 irq on again", {31'b0, irq}, 32'h1);
    bus_write(8'h28, 32'h1);
    idle(2);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    bus_read(8'h2C, d); chk("R9 mask cleared", d, 32'h0);
    bus_read(8'h30, d);
    // R8 fault selection
    bus_write(8'h04, 32'h6500);
    drive_raw(1'b1);
    chk("R8 fault level high", {31'b0, fault}, 32'h1);
    drive_raw(1'b0);
    chk("R8 fault level low", {31'b0, fault}, 32'h0);
    bus_write(8'h04, 32'h4500);
    idle(2);
    chk("R8 fault follows flag", {31'b0, fault}, 32'h1);
    bus_read(8'h30, d);
    idle(2);
    chk("R8 fault flag cleared", {31'b0, fault}, 32'h0);
    bus_write(8'h04, 32'h2500);
    drive_raw(1'b1);
    chk("R8 fault disabled", {31'b0, fault}, 32'h0);
    // R6 read colliding with detection
    bus_write(8'h04, 32'h100);
    drive_raw(1'b0);
    bus_read(8'h30, d);
    cmp_raw = 1'b1;
    idle(2);
    bus_read(8'h30, d); chk("R6 collision read", d, 32'h2);
    bus_read(8'h30, d); chk("R6 flag kept", d, 32'h3);
    // R11 key
    bus_write(8'hE4, 32'h0000_0001);
    bus_read(8'hE4, d); chk("R11 wrong key", d, 32'h0);
    bus_write(8'hE4, 32'h4143_4301);
    bus_read(8'hE4, d); chk("R11 right key", d, 32'h1);
    // R12 protection
    bus_write(8'h04, 32'h0);
    bus_read(8'h04, d); chk("R12 mode frozen", d, 32'h100);
    bus_read(8'hE8, d); chk("R12 violation set", d, 32'h1);
    bus_read(8'hE8, d); chk("R12 violation cleared", d, 32'h0);
    bus_write(8'h94, 32'h0);
    bus_read(8'h94, d); chk("R12 ana frozen", d, 32'h2);
    bus_read(8'hE8, d); chk("R12 violation ana", d, 32'h1);
    // R10 software reset
    bus_write(8'h24, 32'h1);
    bus_write(8'h00, 32'h1);
    bus_read(8'h04, d); chk("R10 mode", d, 32'h0);
    bus_read(8'h2C, d); chk("R10 mask", d, 32'h0);
    bus_read(8'hE4, d); chk("R10 protection", d, 32'h0);
    bus_read(8'h94, d); chk("R10 ana", d, 32'h0);
    bus_read(8'hE8, d); chk("R10 violation", d, 32'h0);
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule